// File: doc/BRIEF.md
# Atomic Memory Access Sequencer

This block sits between a processor load/store port and a 64-bit memory port. It accepts one request at a time and turns it into memory transactions. A request can be a load or store of 1, 2, 4 or 8 bytes, a byte-masked doubleword store, or one of four atomics:

- set-byte: return the byte and write all ones to it.
- swap: write a word and return the old word.
- 32-bit compare-and-swap.
- 64-bit compare-and-swap.

Every memory transaction carries three things:

- a doubleword-aligned address;
- a byte-lane mask;
- a 64-bit data word.

Lanes are big-endian. The byte at offset k within the doubleword sits in data bits [63-8k:56-8k] and is enabled by mask bit 7-k.

An atomic runs as a read followed by a write. The lock output stays high from the read through the write, so nothing else enters in between. A compare-and-swap whose compare fails still issues its write, with an all-zero mask. A configuration input drops that dummy write instead. Loads return data zero- or sign-extended. Atomics return the pre-operation value, zero-extended. Stores return zero.

A request tagged with an ID and an access-type flag is passed unchanged to every transaction it causes. Sub-doubleword accesses whose address is not a multiple of the access size raise an error pulse and touch no memory.

Top module: `amo_seq`

## Requirements
- R1: After reset, req_ready is 1 and mem_valid, mem_lock, rsp_valid and align_err are 0.
- R2: mem_addr is the request address with its low 3 bits cleared. A read's mem_mask has bit 7-k set for each accessed offset k.
- R3: A store (req_op 1) of 2^req_size bytes makes one write. The value's low bytes are placed big-endian at the addressed offset, and only those lanes are masked on. The response data is 0.
- R4: A load (req_op 0) makes one read. The response holds the accessed bytes as a big-endian number. It is sign-extended when req_signed is 1 and zero-extended otherwise.
- R5: A masked store (req_op 2) needs address bits [2:0] to be 0. It writes req_wdata with mem_mask equal to req_pmask.
- R6: An address that is not a multiple of the access size gives a one-cycle align_err pulse one cycle after acceptance. It causes no memory transaction and no response. Atomic sizes are set-byte 1 byte, swap and 32-bit compare-and-swap 4 bytes, 64-bit compare-and-swap and masked store 8 bytes; req_size is ignored for these.
- R7: Set-byte (req_op 3) returns the old byte zero-extended and leaves that byte at 0xFF.
- R8: Swap (req_op 4) writes the low 32 bits of req_wdata to the addressed word and returns the old word zero-extended.
- R9: Compare-and-swap (req_op 5 for a word, 6 for a doubleword) always returns the old value. When the old value equals the low bits of req_cmp, it writes the new value. Otherwise, with cas_skip_dummy at 0, it issues a write with mem_mask 0.
- R10: With cas_skip_dummy at 1, a failing compare-and-swap issues no write. A matching one still writes.
- R11: mem_lock is 1 on both transactions of an atomic and 0 on all others. req_ready stays 0 while mem_lock is 1.
- R12: mem_id and mem_flag equal the request's req_id and req_flag on every transaction, and rsp_id returns req_id. The flag field is carried verbatim: 0 normal, 1 atomic, 2 table walk, 4 code fetch, 8 device.
- R13: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_write, mem_addr, mem_mask and mem_wdata hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cas_skip_dummy | input | 1 | 1: no write after a failing compare-and-swap |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when valid |
| req_op | input | 3 | 0 load, 1 store, 2 masked store, 3 set-byte, 4 swap, 5 cas32, 6 cas64 |
| req_size | input | 2 | log2 of byte count for loads and stores |
| req_signed | input | 1 | Sign-extend load data |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store / swap / new value |
| req_cmp | input | 64 | Compare operand |
| req_pmask | input | 8 | Lane mask for masked store |
| req_id | input | ID_W | Requester ID |
| req_flag | input | FLAG_W | Access-type flag |
| mem_valid | output | 1 | Transaction present |
| mem_ready | input | 1 | Transaction taken |
| mem_write | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Atomic sequence in progress |
| mem_addr | output | ADDR_W | Doubleword-aligned address |
| mem_mask | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Write data |
| mem_id | output | ID_W | Requester ID |
| mem_flag | output | FLAG_W | Access-type flag |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_data | output | 64 | Load data or old value |
| rsp_id | output | ID_W | ID of the completed request |
| align_err | output | 1 | Misalignment pulse |

## Verification
Loads are swept over every size, offset and signedness against memory words whose bytes have both top-bit states. This separates lane-order errors from extension errors and misalignment rejection. Stores are swept the same way while the memory port stalls on alternate cycles, and masked stores run through sixteen mask patterns. Set-byte is tried at every offset and swap at both word halves. Compare-and-swap is run at both widths, with match and mismatch, and with the dummy write on and off. These runs tell the three write outcomes apart by write count and mask.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [2:0] {
      OP_LOAD   = 3'd0,
      OP_STORE  = 3'd1,
      OP_PSTORE = 3'd2,
      OP_SETB   = 3'd3,
      OP_SWAP   = 3'd4,
      OP_CAS32  = 3'd5,
      OP_CAS64  = 3'd6
   } amo_op_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_RD    = 2'd1,
      S_RWAIT = 2'd2,
      S_WR    = 2'd3
   } amo_st_e;

   function automatic logic op_is_atomic(amo_op_e op);
      return (op == OP_SETB) || (op == OP_SWAP) || (op == OP_CAS32) || (op == OP_CAS64);
   endfunction

   function automatic logic op_is_cas(amo_op_e op);
      return (op == OP_CAS32) || (op == OP_CAS64);
   endfunction

endpackage

// File: rtl/amo_lane_place.sv
// Places the low 2^size bytes of a value at byte offset ofs (big-endian lanes)
// and produces the lane enables and per-bit enables of that window.
module amo_lane_place #(
   parameter int DATA_W = 64,
   parameter int OFS_W  = 3,
   parameter int SZ_W   = 2
) (
   input  logic [DATA_W-1:0]   value,
   input  logic [OFS_W-1:0]    ofs,
   input  logic [SZ_W-1:0]     size,
   output logic [DATA_W/8-1:0] lanes,
   output logic [DATA_W-1:0]   bits,
   output logic [DATA_W-1:0]   placed
);
   localparam int BYTES = DATA_W / 8;

   logic [OFS_W:0]      nb;
   logic [OFS_W:0]      shamt;
   logic [DATA_W-1:0]   trimmed;

   assign nb    = (OFS_W+1)'(1) << size;
   assign shamt = (OFS_W+1)'(BYTES) - {1'b0, ofs} - nb;

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign trimmed[8*i +: 8] = ((OFS_W+1)'(i) < nb) ? value[8*i +: 8] : 8'h00;
      assign lanes[i]          = ((OFS_W+1)'(i) >= shamt) && ((OFS_W+1)'(i) < shamt + nb);
      assign bits[8*i +: 8]    = {8{lanes[i]}};
   end

   assign placed = trimmed << {shamt, 3'b000};

endmodule

// File: rtl/amo_lane_pick.sv
// Extracts the 2^size bytes at offset ofs of a big-endian word and extends them.
module amo_lane_pick #(
   parameter int DATA_W = 64,
   parameter int OFS_W  = 3,
   parameter int SZ_W   = 2
) (
   input  logic [DATA_W-1:0] word,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [SZ_W-1:0]   size,
   input  logic              sext,
   output logic [DATA_W-1:0] value
);
   localparam int BYTES = DATA_W / 8;

   logic [OFS_W:0]      nb;
   logic [OFS_W:0]      shamt;
   logic [DATA_W-1:0]   shifted;
   logic [OFS_W+2:0]    sidx;
   logic                fill;

   assign nb      = (OFS_W+1)'(1) << size;
   assign shamt   = (OFS_W+1)'(BYTES) - {1'b0, ofs} - nb;
   assign shifted = word >> {shamt, 3'b000};
   assign sidx    = (OFS_W+3)'({nb, 3'b000} - (OFS_W+4)'(1));
   assign fill    = sext & shifted[sidx];

   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      assign value[8*i +: 8] = ((OFS_W+1)'(i) < nb) ? shifted[8*i +: 8] : {8{fill}};
   end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
   import amo_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int ID_W   = 4,
   parameter int FLAG_W = 4,
   parameter int DATA_W = 64,
   localparam int BYTES = DATA_W / 8,
   localparam int OFS_W = $clog2(BYTES),
   localparam int SZ_W  = $clog2(OFS_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cas_skip_dummy,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [SZ_W-1:0]   req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] req_cmp,
   input  logic [BYTES-1:0]  req_pmask,
   input  logic [ID_W-1:0]   req_id,
   input  logic [FLAG_W-1:0] req_flag,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTES-1:0]  mem_mask,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ID_W-1:0]   mem_id,
   output logic [FLAG_W-1:0] mem_flag,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ID_W-1:0]   rsp_id,
   output logic              align_err
);

   if ((DATA_W % 8) != 0 || (1 << OFS_W) != BYTES) begin : g_bad_width
      $error("amo_seq: DATA_W must be eight times a power of two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("amo_seq: ADDR_W must exceed the lane offset width");
   end

   localparam logic [SZ_W-1:0] SZ_BYTE = SZ_W'(0);
   localparam logic [SZ_W-1:0] SZ_WORD = SZ_W'(2);
   localparam logic [SZ_W-1:0] SZ_FULL = SZ_W'(OFS_W);

   function automatic logic [SZ_W-1:0] eff_size(amo_op_e op, logic [SZ_W-1:0] sz);
      case (op)
         OP_SETB:                    return SZ_BYTE;
         OP_SWAP, OP_CAS32:          return SZ_WORD;
         OP_CAS64, OP_PSTORE:        return SZ_FULL;
         default:                    return sz;
      endcase
   endfunction

   amo_st_e             st_q;
   amo_op_e             op_q;
   logic [SZ_W-1:0]     size_q;
   logic                sext_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wval_q, cmp_q, old_q;
   logic [BYTES-1:0]    pmask_q;
   logic [ID_W-1:0]     id_q;
   logic [FLAG_W-1:0]   flag_q;
   logic                rsp_valid_q, err_q;
   logic [DATA_W-1:0]   rsp_data_q;
   logic [ID_W-1:0]     rsp_id_q;

   // request decode
   amo_op_e             in_op;
   logic [SZ_W-1:0]     in_size;
   logic [OFS_W-1:0]    in_amask;
   logic                in_bad;

   assign in_op    = amo_op_e'(req_op);
   assign in_size  = eff_size(in_op, req_size);
   assign in_amask = OFS_W'((1 << in_size) - 1);
   assign in_bad   = |(req_addr[OFS_W-1:0] & in_amask);

   // lane datapath
   logic [OFS_W-1:0]    ofs;
   logic [DATA_W-1:0]   new_val, new_placed, cmp_placed, lane_bits, cmp_bits_unused;
   logic [BYTES-1:0]    lanes, cmp_lanes_unused;
   logic [DATA_W-1:0]   seen_word, pick_val;
   logic                cas_hit, atomic_q;

   assign ofs      = addr_q[OFS_W-1:0];
   assign atomic_q = op_is_atomic(op_q);
   assign new_val  = (op_q == OP_SETB) ? '1 : wval_q;

   amo_lane_place #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_place_new (
      .value(new_val), .ofs(ofs), .size(size_q),
      .lanes(lanes), .bits(lane_bits), .placed(new_placed));

   amo_lane_place #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_place_cmp (
      .value(cmp_q), .ofs(ofs), .size(size_q),
      .lanes(cmp_lanes_unused), .bits(cmp_bits_unused), .placed(cmp_placed));

   assign seen_word = (st_q == S_RWAIT) ? mem_rdata : old_q;
   assign cas_hit   = ~|((seen_word ^ cmp_placed) & lane_bits);

   amo_lane_pick #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_pick (
      .word(seen_word), .ofs(ofs), .size(size_q),
      .sext(sext_q & (op_q == OP_LOAD)), .value(pick_val));

   // memory port
   logic [BYTES-1:0] wr_mask;

   always_comb begin
      case (op_q)
         OP_PSTORE:          wr_mask = pmask_q;
         OP_CAS32, OP_CAS64: wr_mask = cas_hit ? lanes : '0;
         default:            wr_mask = lanes;
      endcase
   end

   assign req_ready = (st_q == S_IDLE);
   assign mem_valid = (st_q == S_RD) || (st_q == S_WR);
   assign mem_write = (st_q == S_WR);
   assign mem_lock  = atomic_q && (st_q != S_IDLE);
   assign mem_addr  = {addr_q[ADDR_W-1:OFS_W], OFS_W'(0)};
   assign mem_mask  = (st_q == S_WR) ? wr_mask : lanes;
   assign mem_wdata = (op_q == OP_PSTORE) ? wval_q : new_placed;
   assign mem_id    = id_q;
   assign mem_flag  = flag_q;

   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;
   assign rsp_id    = rsp_id_q;
   assign align_err = err_q;

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         op_q        <= OP_LOAD;
         size_q      <= '0;
         sext_q      <= 1'b0;
         addr_q      <= '0;
         wval_q      <= '0;
         cmp_q       <= '0;
         old_q       <= '0;
         pmask_q     <= '0;
         id_q        <= '0;
         flag_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
         rsp_id_q    <= '0;
         err_q       <= 1'b0;
      end else begin
         rsp_valid_q <= 1'b0;
         err_q       <= 1'b0;
         case (st_q)
            S_IDLE: if (req_valid) begin
               if (in_bad) begin
                  err_q    <= 1'b1;
                  rsp_id_q <= req_id;
               end else begin
                  op_q    <= in_op;
                  size_q  <= in_size;
                  sext_q  <= req_signed;
                  addr_q  <= req_addr;
                  wval_q  <= req_wdata;
                  cmp_q   <= req_cmp;
                  pmask_q <= req_pmask;
                  id_q    <= req_id;
                  flag_q  <= req_flag;
                  st_q    <= (in_op == OP_STORE || in_op == OP_PSTORE) ? S_WR : S_RD;
               end
            end
            S_RD: if (mem_ready) st_q <= S_RWAIT;
            S_RWAIT: if (mem_rvalid) begin
               old_q <= mem_rdata;
               if (op_q == OP_LOAD ||
                   (op_is_cas(op_q) && !cas_hit && cas_skip_dummy)) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= pick_val;
                  rsp_id_q    <= id_q;
                  st_q        <= S_IDLE;
               end else begin
                  st_q <= S_WR;
               end
            end
            S_WR: if (mem_ready) begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= atomic_q ? pick_val : '0;
               rsp_id_q    <= id_q;
               st_q        <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/amo_seq_chk.sv
module amo_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic              mem_lock,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W/8-1:0] mem_mask,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              align_err,
   input logic              rsp_valid
);

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr)
                                  && $stable(mem_mask) && $stable(mem_wdata))
      else $error("p_hold_r13");

   p_lock_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> !req_ready)
      else $error("p_lock_busy_r11");

   p_lock_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && !mem_write && mem_lock |=> mem_lock)
      else $error("p_lock_span_r11");

   p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> !mem_valid && !rsp_valid)
      else $error("p_err_quiet_r6");

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready && !mem_lock)
      else $error("p_done_idle_r4");

endmodule

bind amo_seq amo_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
   .mem_ready(mem_ready), .mem_write(mem_write), .mem_lock(mem_lock),
   .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
   .align_err(align_err), .rsp_valid(rsp_valid));

// File: tb/sim_amo_seq.sv
module sim_amo_seq;
   localparam int AW = 16;
   localparam int IW = 4;
   localparam int FW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic           cas_skip_dummy = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [2:0]     req_op = '0;
   logic [1:0]     req_size = '0;
   logic           req_signed = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [63:0]    req_wdata = '0, req_cmp = '0;
   logic [7:0]     req_pmask = '0;
   logic [IW-1:0]  req_id = '0;
   logic [FW-1:0]  req_flag = '0;
   logic           mem_valid, mem_write, mem_lock;
   logic           mem_ready = 1'b1;
   logic [AW-1:0]  mem_addr;
   logic [7:0]     mem_mask;
   logic [63:0]    mem_wdata;
   logic [IW-1:0]  mem_id;
   logic [FW-1:0]  mem_flag;
   logic           mem_rvalid = 1'b0;
   logic [63:0]    mem_rdata = '0;
   logic           rsp_valid, align_err;
   logic [63:0]    rsp_data;
   logic [IW-1:0]  rsp_id;

   amo_seq #(.ADDR_W(AW), .ID_W(IW), .FLAG_W(FW)) u0 (
      .clk(clk), .rst_n(rst_n), .cas_skip_dummy(cas_skip_dummy),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_cmp(req_cmp), .req_pmask(req_pmask),
      .req_id(req_id), .req_flag(req_flag), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_write(mem_write), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
      .mem_id(mem_id), .mem_flag(mem_flag), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_id(rsp_id), .align_err(align_err));

   logic [63:0]   mem [0:7];
   int            n_rd = 0, n_wr = 0, id_bad = 0, lock_bad = 0;
   int            nvec = 0, nfail = 0, cyc = 0;
   logic [7:0]    last_mask = '0;
   logic [IW-1:0] exp_id = '0;
   logic [FW-1:0] exp_flag = '0;
   logic          exp_lock = 1'b0;
   logic          stall_en = 1'b0;
   logic          got_rsp, got_err;
   logic [63:0]   rsp_val;
   logic [IW-1:0] rsp_idv;

   // memory model
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++)
            mem[i] = 64'h0123456789ABCDEF ^ (64'(i) * 64'h1111111111111111);
      end else if (mem_valid && mem_ready) begin
         last_mask = mem_mask;
         if (mem_id !== exp_id || mem_flag !== exp_flag) id_bad++;
         if (mem_lock !== exp_lock) lock_bad++;
         if (mem_write) begin
            for (int b = 0; b < 8; b++)
               if (mem_mask[b]) mem[mem_addr[5:3]][8*b +: 8] = mem_wdata[8*b +: 8];
            n_wr++;
         end else begin
            mem_rdata  <= mem[mem_addr[5:3]];
            mem_rvalid <= 1'b1;
            n_rd++;
         end
      end
   end

   always @(negedge clk) mem_ready <= stall_en ? ~mem_ready : 1'b1;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         nfail++;
         $display("FAIL watchdog expired (all requirements) act=%0d exp<%0d", cyc, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   function automatic logic [63:0] low_ones(int nb);
      return (nb >= 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
   endfunction

   function automatic logic [63:0] extract(logic [63:0] w, int sz, int o, logic sg);
      int nb = 1 << sz;
      logic [63:0] v = (w >> (8*(8-o-nb))) & low_ones(nb);
      if (sg && v[8*nb-1]) v = v | ~low_ones(nb);
      return v;
   endfunction

   function automatic logic [63:0] lane_bits(int sz, int o);
      int nb = 1 << sz;
      return low_ones(nb) << (8*(8-o-nb));
   endfunction

   function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] v, int sz, int o);
      int nb = 1 << sz;
      return (old & ~lane_bits(sz, o)) | ((v & low_ones(nb)) << (8*(8-o-nb)));
   endfunction

   function automatic logic [FW-1:0] flag_of(int n);
      case (n % 5)
         0: return FW'(0);
         1: return FW'(1);
         2: return FW'(2);
         3: return FW'(4);
         default: return FW'(8);
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input int op, input int sz, input logic sg, input int a,
                        input logic [63:0] wd, input logic [63:0] cm, input logic [7:0] pm);
      @(negedge clk);
      exp_id    = IW'(nvec);
      exp_flag  = flag_of(nvec);
      exp_lock  = (op >= 3);
      req_op    = 3'(op);
      req_size  = 2'(sz);
      req_signed = sg;
      req_addr  = AW'(a);
      req_wdata = wd;
      req_cmp   = cm;
      req_pmask = pm;
      req_id    = exp_id;
      req_flag  = exp_flag;
      req_valid = 1'b1;
      @(posedge clk);
      got_rsp = 1'b0;
      got_err = 1'b0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (k == 0) req_valid = 1'b0;
         if (rsp_valid || align_err) begin
            got_rsp = rsp_valid;
            got_err = align_err;
            rsp_val = rsp_data;
            rsp_idv = rsp_id;
            break;
         end
      end
   endtask

   initial begin
      logic [63:0] old, v, ex;
      int r0, w0, idx, a;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", {59'd0, req_ready, mem_valid, mem_lock, rsp_valid, align_err},
          {59'd0, 5'b10000});
      rst_n = 1'b1;

      // R4 / R2 / R6 / R12: load sweep
      for (int sz = 0; sz < 4; sz++)
         for (int o = 0; o < 8; o++)
            for (int sg = 0; sg < 2; sg++) begin
               idx = (o + sz) % 8;
               a = idx * 8 + o;
               old = mem[idx];
               r0 = n_rd;
               do_op(0, sz, sg[0], a, 0, 0, 0);
               if (o % (1 << sz) != 0)
                  chk("R6 misaligned load", {62'(n_rd - r0), got_err, got_rsp}, {62'd0, 2'b10});
               else begin
                  chk("R4 load data", rsp_val, extract(old, sz, o, sg[0]));
                  chk("R2 read lane mask", {56'd0, last_mask},
                      {56'd0, 8'(((1 << (1 << sz)) - 1) << (8 - o - (1 << sz)))});
                  chk("R12 rsp id", {60'd0, rsp_idv}, {60'd0, exp_id});
               end
            end

      // R3 / R13: store sweep under back-pressure
      stall_en = 1'b1;
      for (int sz = 0; sz < 4; sz++)
         for (int o = 0; o < 8; o++) begin
            idx = (o + 3 * sz) % 8;
            a = idx * 8 + o;
            v = 64'hF0E1D2C3B4A59687 ^ (64'(sz * 8 + o) * 64'h0101010101010101);
            old = mem[idx];
            w0 = n_wr;
            do_op(1, sz, 1'b0, a, v, 0, 0);
            if (o % (1 << sz) != 0) begin
               chk("R6 misaligned store err", {63'd0, got_err}, 64'd1);
               chk("R6 misaligned store mem", mem[idx], old);
            end else begin
               chk("R3 store memory", mem[idx], merge(old, v, sz, o));
               chk("R3 store write count/data", {32'(n_wr - w0), rsp_val[31:0]}, {32'd1, 32'd0});
            end
         end
      stall_en = 1'b0;

      // R5 masked store
      for (int k = 0; k < 16; k++) begin
         logic [7:0] pm;
         pm = 8'(k * 37 + 1);
         idx = k % 8;
         v = 64'h5A4B3C2D1E0F6978 + 64'(k);
         old = mem[idx];
         ex = old;
         for (int b = 0; b < 8; b++) if (pm[b]) ex[8*b +: 8] = v[8*b +: 8];
         do_op(2, 0, 1'b0, idx * 8, v, 0, pm);
         chk("R5 masked store", mem[idx], ex);
      end
      old = mem[2];
      do_op(2, 3, 1'b0, 2 * 8 + 4, '1, 0, 8'hFF);
      chk("R5 masked store misaligned", {63'd0, got_err}, 64'd1);
      chk("R5 masked store no write", mem[2], old);

      // R7 set-byte at every offset
      for (int o = 0; o < 8; o++) begin
         old = mem[o];
         do_op(3, 3, 1'b0, o * 8 + o, 0, 0, 0);
         chk("R7 set-byte old value", rsp_val, extract(old, 0, o, 1'b0));
         chk("R7 set-byte memory", mem[o], old | lane_bits(0, o));
      end

      // R8 swap
      for (int h = 0; h < 2; h++) begin
         old = mem[5];
         v = 64'hDEADBEEF_00000000 | 64'(32'h9ABC0123 + h);
         do_op(4, 0, 1'b0, 5 * 8 + 4 * h, v, 0, 0);
         chk("R8 swap old word", rsp_val, extract(old, 2, 4 * h, 1'b0));
         chk("R8 swap memory", mem[5], merge(old, v, 2, 4 * h));
      end
      old = mem[5];
      do_op(4, 0, 1'b0, 5 * 8 + 2, 64'h1, 0, 0);
      chk("R8 swap misaligned err", {63'd0, got_err}, 64'd1);
      chk("R8 swap misaligned memory", mem[5], old);

      // R9 / R10 compare-and-swap
      for (int w = 0; w < 2; w++)
         for (int cfg = 0; cfg < 2; cfg++)
            for (int hit = 0; hit < 2; hit++) begin
               int sz, o;
               logic [63:0] cm;
               sz = w ? 3 : 2;
               o = (w == 0 && hit == 1) ? 4 : 0;
               idx = 6 + w;
               old = mem[idx];
               cm = extract(old, sz, o, 1'b0) ^ (hit ? 64'd0 : 64'h10);
               v = 64'hA5A55A5AC3C33C3C ^ 64'(w * 4 + cfg * 2 + hit);
               cas_skip_dummy = cfg[0];
               w0 = n_wr;
               do_op(w ? 6 : 5, 0, 1'b0, idx * 8 + o, v, cm, 0);
               chk(cfg ? "R10 cas old value" : "R9 cas old value", rsp_val, extract(old, sz, o, 1'b0));
               chk(cfg ? "R10 cas memory" : "R9 cas memory", mem[idx], hit ? merge(old, v, sz, o) : old);
               chk(cfg ? "R10 cas write count" : "R9 cas write count", 64'(n_wr - w0),
                   (hit || !cfg) ? 64'd1 : 64'd0);
               if (!hit && !cfg) chk("R9 dummy write mask", {56'd0, last_mask}, 64'd0);
            end
      cas_skip_dummy = 1'b0;

      chk("R11 lock on atomic transactions only", 64'(lock_bad), 64'd0);
      chk("R12 id and flag forwarded", 64'(id_bad), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule